// File: doc/BRIEF.md
# Prescaled Timer with Watchdog

This block is a free-running binary counter driven by the main clock. Four adjacent high-order bits of the counter form a 4-bit timer value that software reads through a load-from-timer path. A small write-only mode register sets how much of that value is returned. The read can give only the slowest tap, with the three lower bits forced to zero, or all four taps.

The same counter serves two further purposes. With the watchdog enabled, software must clear the counter within a window of 2^WIN_LOG2 main clocks. If it does not, the block issues a one-cycle system reset pulse and restarts the count. While the hold input is high the main clock is treated as stopped, so the counter and mode register freeze. When hold falls, the counter restarts from zero and times an oscillator stabilization wait of 2^STAB_LOG2 clocks. A done flag reports the end of that wait.

Top module: `wdt_prescale_timer`

## Requirements
- R1: After reset, tm_o is 0, wdog_rst_o is 0, stab_done_o is 1 and the read mode is summary (mode bit 0).
- R2: While hold_i is low and nothing clears it, the counter rises by one per clock. With the watchdog disabled it wraps modulo 2^CNT_W.
- R3: In full read mode, tm_o[3:0] equals counter bits [TAP_TOP:TAP_TOP-3], with tm_o[3] the slowest tap. With the defaults these are bits 14 down to 11, whose periods are 2^15 down to 2^12 clocks.
- R4: A write with mode_we_i takes bit 2 of mode_wdata_i as the read mode, and the other bits are ignored. In mode 0, tm_o is {tap3, 3'b000}. In mode 1, all four taps are returned.
- R5: A high clr_i, sampled outside hold, sets the counter to 0 at that edge. This takes priority over a watchdog expiry in the same cycle, so no pulse is issued.
- R6: While wd_en_i is high and no wait is running, wdog_rst_o rises exactly 2^WIN_LOG2 clocks after the last clear. The counter reads 0 in that same cycle.
- R7: Each watchdog pulse lasts exactly one clock.
- R8: While hold_i is sampled high, the counter and the read mode do not change, and clr_i and mode writes have no effect.
- R9: At the first clock edge with hold_i low after a hold, the counter is cleared and stab_done_o falls. stab_done_o rises again 2^STAB_LOG2 clocks later, with the counter cleared. No watchdog pulse is issued during the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous counter clear strobe |
| mode_we_i | input | 1 | Mode register write enable |
| mode_wdata_i | input | 4 | Mode register write data (bit 2 = full read) |
| wd_en_i | input | 1 | Watchdog enable |
| hold_i | input | 1 | Clock-stopped hold indication |
| tm_o | output | 4 | Timer read value |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |
| stab_done_o | output | 1 | Stabilization wait finished |

## Verification
The bench builds the block with CNT_W=10, TAP_TOP=7, WIN_LOG2=8 and STAB_LOG2=6. With these values a full counter wrap takes 1024 clocks, a watchdog window 256 and a stabilization wait 64. Wraps, many expiries and clears landing on the expiry cycle can therefore all occur within a short run. Tap behaviour is the same as with the full-width defaults, only with shorter periods.

// File: rtl/wdt_timer_pkg.sv
package wdt_timer_pkg;
  localparam int unsigned TM_W          = 4;
  localparam int unsigned MODE_W        = 4;
  localparam int unsigned MODE_FULL_BIT = 2;

  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_STAB = 1'b1
  } tmr_phase_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import wdt_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 17,
  parameter int unsigned WIN_LOG2  = 16,
  parameter int unsigned STAB_LOG2 = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wd_en_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clear_o,
  output logic             inc_o,
  output logic             wdog_o,
  output logic             stab_done_o
);
  tmr_phase_e phase_q, phase_d;
  logic hold_q, wd_q;
  logic release_w, win_full, stab_full, stab_end, wd_fire;

  assign release_w = hold_q && !hold_i;
  assign win_full  = &cnt_i[WIN_LOG2-1:0];
  assign stab_full = &cnt_i[STAB_LOG2-1:0];
  assign stab_end  = !hold_i && !release_w && (phase_q == PH_STAB) && stab_full;
  assign wd_fire   = !hold_i && !release_w && !clr_i && wd_en_i &&
                     (phase_q == PH_RUN) && win_full;

  assign inc_o   = !hold_i;
  assign clear_o = !hold_i && (release_w || clr_i || stab_end || wd_fire);

  always_comb begin
    phase_d = phase_q;
    if (release_w)     phase_d = PH_STAB;
    else if (stab_end) phase_d = PH_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RUN;
      hold_q  <= 1'b0;
      wd_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hold_q  <= hold_i;
      wd_q    <= wd_fire;
    end
  end

  assign wdog_o      = wd_q;
  assign stab_done_o = (phase_q == PH_RUN);

  assert_hold_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(cnt_i));
  assert_wd_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q |=> !wd_q);
  assert_wd_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q |-> (cnt_i == '0));
  assert_no_wd_in_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STAB) |-> !wd_q);
  assert_done_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stab_done_o) |-> (cnt_i == '0));
endmodule

// File: rtl/tmr_readout.sv
module tmr_readout
  import wdt_timer_pkg::*;
#(
  parameter int unsigned CNT_W   = 17,
  parameter int unsigned TAP_TOP = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [TM_W-1:0]   tm_o
);
  localparam int unsigned TAP_LO = TAP_TOP - (TM_W - 1);

  logic full_q;
  logic [TM_W-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    full_q <= 1'b0;
    else if (mode_we_i && !hold_i)  full_q <= mode_wdata_i[MODE_FULL_BIT];
  end

  for (genvar i = 0; i < TM_W; i++) begin : g_tap
    if (i == TM_W - 1) begin : g_top
      assign tm_o[i] = cnt_i[TAP_LO + i];
    end else begin : g_low
      assign tm_o[i] = full_q & cnt_i[TAP_LO + i];
    end
    assign taps[i] = cnt_i[TAP_LO + i];
  end

  assert_mode_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(full_q));
  assert_full_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (tm_o == taps));
endmodule

// File: rtl/wdt_prescale_timer.sv
module wdt_prescale_timer
  import wdt_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 17,
  parameter int unsigned TAP_TOP   = 14,
  parameter int unsigned WIN_LOG2  = 16,
  parameter int unsigned STAB_LOG2 = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       mode_we_i,
  input  logic [3:0] mode_wdata_i,
  input  logic       wd_en_i,
  input  logic       hold_i,
  output logic [3:0] tm_o,
  output logic       wdog_rst_o,
  output logic       stab_done_o
);
  logic [CNT_W-1:0] cnt;
  logic clear, inc;

  tmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (inc),
    .cnt_o   (cnt)
  );

  tmr_ctrl #(
    .CNT_W     (CNT_W),
    .WIN_LOG2  (WIN_LOG2),
    .STAB_LOG2 (STAB_LOG2)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .wd_en_i     (wd_en_i),
    .hold_i      (hold_i),
    .cnt_i       (cnt),
    .clear_o     (clear),
    .inc_o       (inc),
    .wdog_o      (wdog_rst_o),
    .stab_done_o (stab_done_o)
  );

  tmr_readout #(.CNT_W(CNT_W), .TAP_TOP(TAP_TOP)) i_readout (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hold_i       (hold_i),
    .mode_we_i    (mode_we_i),
    .mode_wdata_i (mode_wdata_i),
    .cnt_i        (cnt),
    .tm_o         (tm_o)
  );

  initial begin
    assert (TAP_TOP < CNT_W && TAP_TOP >= TM_W - 1);
    assert (WIN_LOG2 >= 1 && WIN_LOG2 <= CNT_W);
    assert (STAB_LOG2 >= 1 && STAB_LOG2 <= CNT_W);
  end

  assert_clr_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hold_i) |=> (tm_o == '0 && !wdog_rst_o));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !clear) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/test_wdt_prescale_timer.sv
module test_wdt_prescale_timer;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CNT_W      = 10;
  localparam int unsigned TAP_TOP    = 7;
  localparam int unsigned WIN_LOG2   = 8;
  localparam int unsigned STAB_LOG2  = 6;
  localparam int unsigned TAP_LO     = TAP_TOP - 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, mode_we = 1'b0, wd_en = 1'b0, hold = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic [3:0] tm;
  logic wdog, done;

  int unsigned errors = 0, checks = 0, cycles = 0;
  bit model_on = 1'b0;

  wdt_prescale_timer #(
    .CNT_W(CNT_W), .TAP_TOP(TAP_TOP), .WIN_LOG2(WIN_LOG2), .STAB_LOG2(STAB_LOG2)
  ) i_wdt_prescale_timer (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .mode_we_i(mode_we),
    .mode_wdata_i(mode_wdata), .wd_en_i(wd_en), .hold_i(hold),
    .tm_o(tm), .wdog_rst_o(wdog), .stab_done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state built from the requirements
  logic [CNT_W-1:0] m_cnt;
  logic m_full, m_stab, m_hold_q, m_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_full <= 1'b0; m_stab <= 1'b0; m_hold_q <= 1'b0; m_wd <= 1'b0;
    end else begin
      m_hold_q <= hold;
      m_wd     <= 1'b0;
      if (!hold) begin
        if (mode_we) m_full <= mode_wdata[2];
        if (m_hold_q) begin
          m_cnt <= '0; m_stab <= 1'b1;
        end else if (clr) begin
          m_cnt <= '0;
        end else if (m_stab && (m_cnt[STAB_LOG2-1:0] == {STAB_LOG2{1'b1}})) begin
          m_cnt <= '0; m_stab <= 1'b0;
        end else if (wd_en && !m_stab && (m_cnt[WIN_LOG2-1:0] == {WIN_LOG2{1'b1}})) begin
          m_cnt <= '0; m_wd <= 1'b1;
        end else begin
          m_cnt <= m_cnt + 1'b1;
        end
      end
    end
  end

  function automatic logic [3:0] exp_tm(logic [CNT_W-1:0] c, logic full);
    logic [3:0] t = c[TAP_LO +: 4];
    return full ? t : {t[3], 3'b000};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      check("R3", tm, exp_tm(m_cnt, m_full));
      check("R6", wdog, m_wd);
      check("R9", done, !m_stab);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [3:0] frozen;
    step(3);
    check("R1", {tm, wdog, done}, {4'h0, 1'b0, 1'b1});
    rst_n = 1'b1;
    step(1);
    model_on = 1'b1;

    // R4: summary mode after reset, then switch to full via bit 2 only
    mode_we = 1'b1; mode_wdata = 4'b1011; step(1); // bit2=0 keeps summary
    mode_we = 1'b0; step(20);
    check("R4", tm[2:0], 3'b000);
    mode_we = 1'b1; mode_wdata = 4'b0100; step(1); mode_we = 1'b0;

    // R2: count and wrap
    clr = 1'b1; step(1); clr = 1'b0;
    step(16);
    check("R2", tm, 4'h1);
    step(1007);
    check("R2", tm, 4'hF);
    step(1);
    check("R2", tm, 4'h0);

    // R6 / R7: expiry exactly after the window
    wd_en = 1'b1; clr = 1'b1; step(1); clr = 1'b0;
    step(255);
    check("R6", wdog, 1'b0);
    step(1);
    check("R6", {wdog, tm}, {1'b1, 4'h0});
    step(1);
    check("R7", wdog, 1'b0);

    // R5: clear on the expiry cycle wins
    clr = 1'b1; step(1); clr = 1'b0;
    step(255);
    clr = 1'b1; step(1); clr = 1'b0;
    check("R5", {wdog, tm}, {1'b0, 4'h0});
    step(1);
    check("R5", wdog, 1'b0);

    // R8: hold freezes everything
    wd_en = 1'b0; step(40);
    hold = 1'b1; step(1);
    frozen = tm;
    clr = 1'b1; mode_we = 1'b1; mode_wdata = 4'b0000; step(1);
    clr = 1'b0; mode_we = 1'b0; step(3);
    check("R8", tm, frozen);

    // R9: release starts the stabilization wait
    hold = 1'b0; step(1);
    check("R9", {done, tm}, {1'b0, 4'h0});
    wd_en = 1'b1; step(63);
    check("R9", {done, wdog}, {1'b0, 1'b0});
    step(1);
    check("R9", done, 1'b1);

    // constrained random mix, fixed seed
    void'($urandom(32'h5eed_7a11));
    for (int n = 0; n < 20000; n++) begin
      clr     = ($urandom_range(0, 399) == 0);
      mode_we = ($urandom_range(0, 99) == 0);
      mode_wdata = 4'($urandom);
      if ($urandom_range(0, 499) == 0) wd_en = ~wd_en;
      if (hold) hold = ($urandom_range(0, 19) != 0);
      else      hold = ($urandom_range(0, 799) == 0);
      step(1);
    end
    hold = 1'b0; clr = 1'b0; mode_we = 1'b0;
    step(100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule